// File: doc/BRIEF.md
# Bicubic Pixel Interpolator

This block produces one resampled 8-bit grey level from a 4x4 patch of source pixels and a fractional sample position. The caller supplies the sixteen neighbours of the integer position (i, j), rows i-1..i+2 and columns j-1..j+2, together with the 8-bit fractions u and v in units of 1/256, the pixel found at (i, j) itself and an 8-bit rejection threshold. The block turns each fraction into four signed cubic weights with an integer scale of 256. It filters every column of the patch with the u weights, then blends the four column sums with the v weights. The result is rounded, clamped to the pixel range and compared with the source pixel.

When the interpolated value strays from the source pixel by more than the threshold, the source pixel is emitted instead. This suppresses ringing artefacts around hard edges. Requests and results move through a valid/ready handshake. The datapath is a four-register pipeline that accepts one request per clock. When the consumer holds off, every stage freezes at once.

Top module: `bicubic_interp`

## Requirements
- R1: For a fraction f = u/256 the taps t = 0..3 use the cubic kernel at x = f + 1 - t. For |x| < 1 the kernel is 1 - 2|x|^2 + |x|^3. For 1 <= |x| < 2 it is 4 - 8|x| + 5|x|^2 - |x|^3. For |x| >= 2 it is zero. Taps 0, 2 and 3 are 256*S(x) rounded to the nearest integer, with halves rounded up. Tap 1 is 256 minus the other three. Tap weights are signed.
- R2: Patch pixel k, bits [8k+7:8k] of `in_pix`, sits at row k/4 and column k%4, where row 1 / column 1 is (i, j). The u weights act along rows and produce one sum per column. The v weights then combine the four column sums.
- R3: The two-stage sum, scaled by 65536, is rounded by adding 32768 and shifting right arithmetically by 16. An exact half therefore rounds up.
- R4: The rounded value is clamped to 0..255 before the threshold test.
- R5: If |clamped - in_src| > in_thr, the output is in_src. Otherwise the output is the clamped value. Equality keeps the interpolated value.
- R6: A threshold of 255 never causes replacement.
- R7: A request accepted on clock edge k appears with out_valid after edge k+3. Back-to-back requests are accepted on every clock while out_ready is high.
- R8: While out_valid is high and out_ready is low, out_pix and out_valid hold and in_ready is low. No result is lost or repeated.
- R9: After synchronous reset, out_valid is low and in_ready is high.
- R10: A patch of sixteen equal pixels reproduces that value exactly for every u and v.
- R11: With u = v = 0 the interpolated value equals the row 1 / column 1 pixel (pixel index 5).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request accepted this cycle when high together with in_valid |
| in_pix | input | 128 | Sixteen 8-bit patch pixels, pixel k at bits [8k+7:8k], row-major |
| in_u | input | 8 | Row-direction fraction in units of 1/256 |
| in_v | input | 8 | Column-direction fraction in units of 1/256 |
| in_src | input | 8 | Source pixel at the integer position |
| in_thr | input | 8 | Replacement threshold |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer accepts the result |
| out_pix | output | 8 | Result pixel |

## Verification
Clamping and replacement can act on the same result. A patch whose edge overshoots past 255 is sent with a source pixel of 200. The threshold is set once just below and once exactly at the distance from the clamped value. With a threshold of 54 the source must come out, and with 55 the value 255 must come out. An unclamped comparison would have replaced the result in both cases. Separately, a randomly throttled out_ready stalls the pipe while new requests keep arriving. This checks that held outputs stay stable and that every result leaves exactly once, in order.

// File: rtl/bicubic_pkg.sv
package bicubic_pkg;
  localparam int TAPS = 4;
  localparam int NBR  = TAPS * TAPS;
endpackage

// File: rtl/bicubic_kernel.sv
module bicubic_kernel
  import bicubic_pkg::*;
#(
  parameter int FRAC_W = 8,
  parameter int WGT_W  = FRAC_W + 2
) (
  input  logic [FRAC_W-1:0]       frac,
  output logic [TAPS*WGT_W-1:0]   wgt
);
  localparam int CW = 3 * FRAC_W + 4;
  localparam int SH = 2 * FRAC_W;
  localparam logic signed [CW-1:0]    HALF = CW'(1) <<< (SH - 1);
  localparam logic signed [WGT_W-1:0] ONE  = WGT_W'(1) <<< FRAC_W;

  logic signed [CW-1:0]    f, t1, t2, t3, a0, a2, a3;
  logic signed [WGT_W-1:0] w [TAPS];

  function automatic logic signed [WGT_W-1:0] rnd(input logic signed [CW-1:0] a);
    return WGT_W'((a + HALF) >>> SH);
  endfunction

  always_comb begin
    f  = $signed({{(CW-FRAC_W){1'b0}}, frac});
    t1 = f <<< SH;
    t2 = (f * f) <<< FRAC_W;
    t3 = f * f * f;
    a0 = t2 + t2 - t1 - t3;
    a2 = t1 + t2 - t3;
    a3 = t3 - t2;
    w[0] = rnd(a0);
    w[2] = rnd(a2);
    w[3] = rnd(a3);
    w[1] = ONE - w[0] - w[2] - w[3];
  end

  for (genvar t = 0; t < TAPS; t++) begin : g_pack
    assign wgt[t*WGT_W +: WGT_W] = w[t];
  end

  always_comb begin
    for (int t = 0; t < TAPS; t++) begin
      p_wgt_range_r1: assert (w[t] >= -(ONE >>> 2) && w[t] <= ONE)
        else $error("weight out of range");
    end
    if (frac == '0) begin
      p_zero_frac_r11: assert (w[0] == 0 && w[1] == ONE && w[2] == 0 && w[3] == 0)
        else $error("zero fraction weights wrong");
    end
  end
endmodule

// File: rtl/bicubic_mac4.sv
module bicubic_mac4
  import bicubic_pkg::*;
#(
  parameter int A_W = 9,
  parameter int B_W = 10,
  parameter int S_W = 21
) (
  input  logic [TAPS*A_W-1:0] a,
  input  logic [TAPS*B_W-1:0] b,
  output logic signed [S_W-1:0] s
);
  always_comb begin
    s = '0;
    for (int k = 0; k < TAPS; k++) begin
      s = s + S_W'($signed(a[k*A_W +: A_W])) * S_W'($signed(b[k*B_W +: B_W]));
    end
  end
endmodule

// File: rtl/bicubic_guard.sv
module bicubic_guard #(
  parameter int ACC_W = 33,
  parameter int PIX_W = 8,
  parameter int SH    = 16
) (
  input  logic signed [ACC_W-1:0] acc,
  input  logic [PIX_W-1:0]        src,
  input  logic [PIX_W-1:0]        thr,
  output logic [PIX_W-1:0]        pix
);
  localparam logic signed [ACC_W-1:0] HALF = ACC_W'(1) <<< (SH - 1);
  localparam logic signed [ACC_W-1:0] MAXV = ACC_W'((1 << PIX_W) - 1);

  logic signed [ACC_W-1:0] r;
  logic [PIX_W-1:0] sat, diff, odiff;

  always_comb begin
    r = (acc + HALF) >>> SH;
    if (r < 0)          sat = '0;
    else if (r > MAXV)  sat = '1;
    else                sat = r[PIX_W-1:0];
    diff = (sat >= src) ? sat - src : src - sat;
    pix  = (diff > thr) ? src : sat;
  end

  always_comb begin
    odiff = (pix >= src) ? pix - src : src - pix;
    p_thr_bound_r5: assert (odiff <= thr) else $error("result beyond threshold");
    if (&thr) begin
      p_thr_open_r6: assert (pix == sat) else $error("replaced with open threshold");
    end
  end
endmodule

// File: rtl/bicubic_interp.sv
module bicubic_interp
  import bicubic_pkg::*;
#(
  parameter int PIX_W  = 8,
  parameter int FRAC_W = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic [NBR*PIX_W-1:0]   in_pix,
  input  logic [FRAC_W-1:0]      in_u,
  input  logic [FRAC_W-1:0]      in_v,
  input  logic [PIX_W-1:0]       in_src,
  input  logic [PIX_W-1:0]       in_thr,
  output logic                   out_valid,
  input  logic                   out_ready,
  output logic [PIX_W-1:0]       out_pix
);
  localparam int WGT_W = FRAC_W + 2;
  localparam int A_W   = PIX_W + 1;
  localparam int T_W   = A_W + WGT_W + 2;
  localparam int ACC_W = T_W + WGT_W + 2;
  localparam int SH    = 2 * FRAC_W;

  logic adv;
  assign adv      = !out_valid || out_ready;
  assign in_ready = adv;

  // stage A: patch capture and weights
  logic [TAPS*WGT_W-1:0] wu_n, wv_n, wu_a, wv_a;
  logic [NBR*PIX_W-1:0]  pix_a;
  logic [PIX_W-1:0]      src_a, thr_a;
  logic                  va;

  bicubic_kernel #(.FRAC_W(FRAC_W), .WGT_W(WGT_W)) u_kern_u (.frac(in_u), .wgt(wu_n));
  bicubic_kernel #(.FRAC_W(FRAC_W), .WGT_W(WGT_W)) u_kern_v (.frac(in_v), .wgt(wv_n));

  // stage B: per-column sums along rows
  logic [TAPS*A_W-1:0]  colv [TAPS];
  logic [TAPS*T_W-1:0]  tmp_n, tmp_b;
  logic [TAPS*WGT_W-1:0] wv_b;
  logic [PIX_W-1:0]     src_b, thr_b;
  logic                 vb;

  for (genvar c = 0; c < TAPS; c++) begin : g_col
    for (genvar r = 0; r < TAPS; r++) begin : g_row
      assign colv[c][r*A_W +: A_W] = {1'b0, pix_a[(r*TAPS+c)*PIX_W +: PIX_W]};
    end
    logic signed [T_W-1:0] s_col;
    bicubic_mac4 #(.A_W(A_W), .B_W(WGT_W), .S_W(T_W)) u_mac_col (
      .a(colv[c]), .b(wu_a), .s(s_col));
    assign tmp_n[c*T_W +: T_W] = s_col;
  end

  // stage C: blend of column sums
  logic signed [ACC_W-1:0] acc_n, acc_c;
  logic [PIX_W-1:0]        src_c, thr_c;
  logic                    vc;

  bicubic_mac4 #(.A_W(T_W), .B_W(WGT_W), .S_W(ACC_W)) u_mac_row (
    .a(tmp_b), .b(wv_b), .s(acc_n));

  // stage D: round, clamp, guard
  logic [PIX_W-1:0] pix_n;
  bicubic_guard #(.ACC_W(ACC_W), .PIX_W(PIX_W), .SH(SH)) u_guard (
    .acc(acc_c), .src(src_c), .thr(thr_c), .pix(pix_n));

  always_ff @(posedge clk) begin
    if (rst) begin
      va        <= 1'b0;
      vb        <= 1'b0;
      vc        <= 1'b0;
      out_valid <= 1'b0;
    end else if (adv) begin
      va        <= in_valid;
      vb        <= va;
      vc        <= vb;
      out_valid <= vc;
    end
  end

  always_ff @(posedge clk) begin
    if (adv) begin
      pix_a   <= in_pix;
      wu_a    <= wu_n;
      wv_a    <= wv_n;
      src_a   <= in_src;
      thr_a   <= in_thr;
      tmp_b   <= tmp_n;
      wv_b    <= wv_a;
      src_b   <= src_a;
      thr_b   <= thr_a;
      acc_c   <= acc_n;
      src_c   <= src_b;
      thr_c   <= thr_b;
      out_pix <= pix_n;
    end
  end

  logic rst_q;
  always_ff @(posedge clk) begin
    rst_q <= rst;
    if (rst_q) begin
      p_idle_after_reset_r9: assert (!out_valid) else $error("valid after reset");
    end
  end

  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_pix)))
    else $error("stalled output changed");

  p_stall_blocks_input_r8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |-> !in_ready)
    else $error("input accepted during stall");
endmodule

// File: tb/sim_bicubic_interp.sv
module sim_bicubic_interp;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic         in_valid = 1'b0, in_ready, out_valid, out_ready = 1'b1;
  logic [127:0] in_pix = '0;
  logic [7:0]   in_u = '0, in_v = '0, in_src = '0, in_thr = '0, out_pix;

  bicubic_interp u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_pix(in_pix), .in_u(in_u), .in_v(in_v), .in_src(in_src), .in_thr(in_thr),
    .out_valid(out_valid), .out_ready(out_ready), .out_pix(out_pix));

  int    n_chk = 0, n_bad = 0;
  int    exp_q[$];
  string tag_q[$];
  bit    bp_mode = 1'b0;
  bit    prev_stall = 1'b0;
  logic [7:0] prev_pix = '0;

  task automatic check(input string req, input int act, input int expv);
    n_chk++;
    if (act != expv) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  // kernel weight per R1, evaluated in real arithmetic
  function automatic int kw(input int u, input int tap);
    real x, a, s;
    x = u / 256.0 + 1.0 - tap;
    a = (x < 0.0) ? -x : x;
    if (a < 1.0)      s = 1.0 - 2.0*a*a + a*a*a;
    else if (a < 2.0) s = 4.0 - 8.0*a + 5.0*a*a - a*a*a;
    else              s = 0.0;
    return $rtoi($floor(s * 256.0 + 0.5));
  endfunction

  function automatic int px(input logic [127:0] p, input int r, input int c);
    return int'(p[(r*4+c)*8 +: 8]);
  endfunction

  function automatic int ref_pix(input logic [127:0] p, input int u, input int v,
                                 input int src, input int thr);
    int wu[4], wv[4];
    longint tmp, acc, res;
    int diff;
    for (int t = 0; t < 4; t++) begin wu[t] = kw(u, t); wv[t] = kw(v, t); end
    wu[1] = 256 - wu[0] - wu[2] - wu[3];
    wv[1] = 256 - wv[0] - wv[2] - wv[3];
    acc = 0;
    for (int c = 0; c < 4; c++) begin
      tmp = 0;
      for (int r = 0; r < 4; r++) tmp += longint'(wu[r]) * px(p, r, c);
      acc += longint'(wv[c]) * tmp;
    end
    res = (acc + 32768) >>> 16;
    if (res < 0) res = 0;
    if (res > 255) res = 255;
    diff = (int'(res) > src) ? int'(res) - src : src - int'(res);
    return (diff > thr) ? src : int'(res);
  endfunction

  function automatic logic [127:0] rnd_patch();
    logic [127:0] p;
    for (int k = 0; k < 16; k++) p[k*8 +: 8] = 8'($urandom);
    return p;
  endfunction

  function automatic logic [127:0] flat_patch(input int val);
    logic [127:0] p;
    for (int k = 0; k < 16; k++) p[k*8 +: 8] = 8'(val);
    return p;
  endfunction

  // output monitor and scoreboard
  initial begin
    forever begin
      @(negedge clk); #2;
      if (rst) prev_stall = 1'b0;
      else begin
        if (prev_stall) begin
          check("R8 held valid", int'(out_valid), 1);
          check("R8 held data", int'(out_pix), int'(prev_pix));
        end
        if (out_valid && out_ready) begin
          if (exp_q.size() == 0) check("R8 spurious result", 1, 0);
          else check(tag_q.pop_front(), int'(out_pix), exp_q.pop_front());
        end
        prev_stall = out_valid && !out_ready;
        prev_pix   = out_pix;
      end
    end
  end

  initial begin
    forever begin
      @(negedge clk);
      if (bp_mode) out_ready = ($urandom % 3) != 0;
    end
  end

  task automatic send(input logic [127:0] p, input int u, input int v, input int src,
                      input int thr, input int expv, input string tag, output int tries);
    @(negedge clk);
    in_valid = 1'b1; in_pix = p; in_u = 8'(u); in_v = 8'(v);
    in_src = 8'(src); in_thr = 8'(thr);
    tries = 0;
    forever begin
      #1;
      tries++;
      if (in_ready) begin
        @(posedge clk);
        exp_q.push_back((expv < 0) ? ref_pix(p, u, v, src, thr) : expv);
        tag_q.push_back(tag);
        break;
      end else @(negedge clk);
    end
  endtask

  task automatic go_idle();
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic drain();
    int k = 0;
    while (exp_q.size() != 0 && k < 2000) begin @(negedge clk); k++; end
    @(negedge clk); #3;
    check("R8 all results delivered", exp_q.size(), 0);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    check("R9 valid low in reset", int'(out_valid), 0);
    rst = 1'b0;
    @(negedge clk); #1;
    check("R9 valid low after reset", int'(out_valid), 0);
    check("R9 ready high after reset", int'(in_ready), 1);
  endtask

  task automatic t_zero_frac();
    int tr;
    for (int n = 0; n < 4; n++) begin
      logic [127:0] p = rnd_patch();
      send(p, 0, 0, 0, 255, px(p, 1, 1), "R11 zero fraction picks centre", tr);
    end
    go_idle(); drain();
  endtask

  task automatic t_flat();
    int tr;
    int vals[4] = '{0, 255, 17, 200};
    int fr[4]   = '{1, 128, 255, 77};
    for (int a = 0; a < 4; a++)
      for (int b = 0; b < 4; b++)
        send(flat_patch(vals[a]), fr[b], fr[3-b], vals[a], 0, vals[a], "R10 flat patch", tr);
    go_idle(); drain();
  endtask

  task automatic t_direction();
    int tr;
    logic [127:0] p = '0;
    for (int r = 0; r < 4; r++)
      for (int c = 0; c < 4; c++) p[(r*4+c)*8 +: 8] = 8'(60*r + 10);
    // rows differ, columns constant: v blend must not disturb the row-1 value
    send(p, 0, 128, 0, 255, 70, "R2 u acts along rows", tr);
    p = '0;
    for (int r = 0; r < 4; r++)
      for (int c = 0; c < 4; c++) p[(r*4+c)*8 +: 8] = 8'(60*c + 10);
    send(p, 128, 0, 0, 255, 70, "R2 v acts along columns", tr);
    go_idle(); drain();
  endtask

  task automatic t_round();
    int tr;
    logic [127:0] p = '0;
    // u=0, v=128: sum = (-32*P[1][0] + 160*P[1][1]) / 256 = 0.5
    p[(4+0)*8 +: 8] = 8'd1;
    p[(4+1)*8 +: 8] = 8'd1;
    send(p, 0, 128, 0, 255, 1, "R3 half rounds up", tr);
    p = '0;
    p[(4+0)*8 +: 8] = 8'd4;   // -0.5 rounds to 0
    p[(4+1)*8 +: 8] = 8'd0;
    send(p, 0, 128, 0, 255, 0, "R3 negative half", tr);
    go_idle(); drain();
  endtask

  task automatic t_kernel_mix();
    int tr;
    int us[6] = '{1, 64, 85, 128, 200, 255};
    for (int a = 0; a < 6; a++)
      for (int b = 0; b < 6; b++)
        send(rnd_patch(), us[a], us[b], 0, 255, -1, "R1 weights vs kernel", tr);
    go_idle(); drain();
  endtask

  task automatic t_sat();
    int tr;
    logic [127:0] hi = '0, lo = '0;
    for (int c = 0; c < 4; c++) begin
      for (int r = 1; r < 4; r++) hi[(r*4+c)*8 +: 8] = 8'd255;
      lo[c*8 +: 8] = 8'd255;
    end
    send(hi, 128, 0, 255, 0, 255, "R4 overshoot clamps to 255", tr);
    send(lo, 128, 0, 0, 0, 0, "R4 undershoot clamps to 0", tr);
    send(hi, 128, 0, 200, 54, 200, "R4 R5 clamp then replace", tr);
    send(hi, 128, 0, 200, 55, 255, "R4 R5 clamp then keep", tr);
    go_idle(); drain();
  endtask

  task automatic t_thr();
    int tr;
    send(flat_patch(100), 77, 77, 110, 10, 100, "R5 equal distance keeps", tr);
    send(flat_patch(100), 77, 77, 110, 9, 110, "R5 larger distance replaces", tr);
    send(flat_patch(100), 77, 77, 90, 9, 90, "R5 replace from below", tr);
    send(flat_patch(255), 30, 90, 0, 255, 255, "R6 open threshold high", tr);
    send(flat_patch(0), 30, 90, 255, 255, 0, "R6 open threshold low", tr);
    for (int n = 0; n < 8; n++)
      send(rnd_patch(), $urandom % 256, $urandom % 256, $urandom % 256, $urandom % 64,
           -1, "R5 random threshold", tr);
    go_idle(); drain();
  endtask

  task automatic t_latency();
    int tr;
    send(flat_patch(42), 10, 20, 42, 0, 42, "R7 single result", tr);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      if (i == 0) in_valid = 1'b0;
      #1;
      check($sformatf("R7 valid after edge k+%0d", i), int'(out_valid), (i == 3) ? 1 : 0);
    end
    drain();
  endtask

  task automatic t_stream();
    int tr, total = 0;
    for (int n = 0; n < 24; n++) begin
      send(rnd_patch(), $urandom % 256, $urandom % 256, $urandom % 256, $urandom % 256,
           -1, "R7 streamed result", tr);
      total += tr;
    end
    go_idle();
    check("R7 one accept per clock", total, 24);
    drain();
  endtask

  task automatic t_backpressure();
    int tr;
    bp_mode = 1'b1;
    for (int n = 0; n < 60; n++)
      send(rnd_patch(), $urandom % 256, $urandom % 256, $urandom % 256, $urandom % 256,
           -1, "R8 result under stalls", tr);
    go_idle();
    drain();
    bp_mode = 1'b0;
    @(negedge clk);
    out_ready = 1'b1;
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    t_reset();
    t_zero_frac();
    t_flat();
    t_direction();
    t_round();
    t_kernel_mix();
    t_sat();
    t_thr();
    t_latency();
    t_stream();
    t_backpressure();
    summary();
    $finish;
  end
endmodule